// File: doc/BRIEF.md
# Registered Shift/Rotate Unit

This block moves a 16-bit word left or right by 0 to 15 positions in a single pass. Three independent control bits choose the behaviour: one selects between shifting (vacated positions are filled) and rotating (bits that leave one end re-enter at the other). One selects zero fill or sign fill for shifts. One selects the direction. The amount is a 4-bit unsigned value.

The datapath is a cascade of four levels that move the word by 8, 4, 2 and 1 positions, each enabled by one bit of the amount. Left moves reuse the same right-moving network: the word is bit-mirrored on entry and mirrored back on exit. The result is captured in an output register, so Q shows the result for the inputs present at the previous rising clock edge. An active-low asynchronous reset clears Q.

Top module: `shf_barrel_top`

## Requirements
- R1: While reset is asserted Q reads 0x0000. After reset is released, Q shows the result for the inputs sampled at the previous rising edge of the clock.
- R2: An amount of 0 copies the data to Q unchanged for every combination of the rotate, arithmetic and direction bits.
- R3: Logical left shift (rotate=0, arith=0, dir=0) moves bits toward the MSB and fills the low `amt` positions with 0. For example, 0x8000 by 1 gives 0x0000.
- R4: Logical right shift (rotate=0, arith=0, dir=1) moves bits toward the LSB and fills the high `amt` positions with 0.
- R5: Arithmetic right shift (rotate=0, arith=1, dir=1) fills the high `amt` positions with copies of data bit 15.
- R6: Arithmetic left shift (rotate=0, arith=1, dir=0) gives the same result as logical left shift.
- R7: Rotate left (rotate=1, dir=0) moves bits toward the MSB, and bit 15 wraps into bit 0. For example, 0x8000 by 1 gives 0x0001.
- R8: Rotate right (rotate=1, dir=1) moves bits toward the LSB, and bit 0 wraps into bit 15.
- R9: When rotate=1 the arith bit has no effect on Q.
- R10: Every amount from 0 through 15 is honoured in each mode. A rotation never changes the number of set bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| data_i | input | 16 | Word to be moved |
| amt_i | input | 4 | Distance in bit positions, 0 to 15 |
| rot_i | input | 1 | 1 = rotate, 0 = shift with fill |
| arith_i | input | 1 | 1 = sign fill on right shifts |
| dir_i | input | 1 | 0 = left, 1 = right |
| q_o | output | 16 | Registered result |

## Verification
Every result is due exactly one rising edge after its inputs are applied, because the only register on the path is the output register. The bench changes the inputs on a falling edge and compares Q on the next falling edge, which is half a cycle after the capturing edge. No sample therefore lands on an edge where Q is still changing. Expected words come from a reference function in the bench that uses plain wide shifts and ORs, and each case is checked against it. This includes the full sweep of amounts in every mode and the 0x8000 cases.

// File: rtl/shf_pkg.sv
package shf_pkg;

    typedef enum logic [1:0] {
        SHF_MODE_LOGIC  = 2'd0,
        SHF_MODE_ARITH  = 2'd1,
        SHF_MODE_ROTATE = 2'd2
    } shf_mode_e;

endpackage

// File: rtl/shf_ctrl.sv
module shf_ctrl
    import shf_pkg::*;
(
    input  logic      rot_i,
    input  logic      arith_i,
    input  logic      dir_i,
    input  logic      msb_i,
    output shf_mode_e mode_o,
    output logic      mirror_o,
    output logic      fill_o
);
    always_comb begin
        if (rot_i) begin
            mode_o = SHF_MODE_ROTATE;
        end else if (arith_i && dir_i) begin
            mode_o = SHF_MODE_ARITH;
        end else begin
            mode_o = SHF_MODE_LOGIC;
        end
        mirror_o = ~dir_i;
        fill_o   = (mode_o == SHF_MODE_ARITH) ? msb_i : 1'b0;
    end
endmodule

// File: rtl/shf_mirror.sv
module shf_mirror #(
    parameter int W = 16
) (
    input  logic         en_i,
    input  logic [W-1:0] vec_i,
    output logic [W-1:0] vec_o
);
    logic [W-1:0] flipped;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign flipped[i] = vec_i[W-1-i];
    end

    assign vec_o = en_i ? flipped : vec_i;
endmodule

// File: rtl/shf_stage.sv
module shf_stage #(
    parameter int W    = 16,
    parameter int DIST = 1
) (
    input  logic         en_i,
    input  logic         rot_i,
    input  logic         fill_i,
    input  logic [W-1:0] vec_i,
    output logic [W-1:0] vec_o
);
    logic [W-1:0] moved;

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (i + DIST < W) begin : g_in
            assign moved[i] = vec_i[i+DIST];
        end else begin : g_edge
            assign moved[i] = rot_i ? vec_i[i+DIST-W] : fill_i;
        end
    end

    assign vec_o = en_i ? moved : vec_i;
endmodule

// File: rtl/shf_barrel_top.sv
module shf_barrel_top
    import shf_pkg::*;
#(
    parameter int WIDTH = 16,
    localparam int AMT_W = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] data_i,
    input  logic [AMT_W-1:0] amt_i,
    input  logic             rot_i,
    input  logic             arith_i,
    input  logic             dir_i,
    output logic [WIDTH-1:0] q_o
);
    typedef struct packed {
        logic [WIDTH-1:0] word;
    } shf_state_t;

    shf_state_t state_d, state_q;

    shf_mode_e mode;
    logic      mirror;
    logic      fill;

    logic [WIDTH-1:0] lane [AMT_W+1];
    logic [WIDTH-1:0] net_out;

    shf_ctrl u_ctrl (
        .rot_i   (rot_i),
        .arith_i (arith_i),
        .dir_i   (dir_i),
        .msb_i   (data_i[WIDTH-1]),
        .mode_o  (mode),
        .mirror_o(mirror),
        .fill_o  (fill)
    );

    shf_mirror #(.W(WIDTH)) u_mirror_in (
        .en_i (mirror),
        .vec_i(data_i),
        .vec_o(lane[0])
    );

    // Levels ordered from the largest distance to the smallest.
    for (genvar s = 0; s < AMT_W; s++) begin : g_level
        localparam int BIT = AMT_W - 1 - s;
        shf_stage #(.W(WIDTH), .DIST(1 << BIT)) u_stage (
            .en_i  (amt_i[BIT]),
            .rot_i (mode == SHF_MODE_ROTATE),
            .fill_i(fill),
            .vec_i (lane[s]),
            .vec_o (lane[s+1])
        );
    end

    shf_mirror #(.W(WIDTH)) u_mirror_out (
        .en_i (mirror),
        .vec_i(lane[AMT_W]),
        .vec_o(net_out)
    );

    always_comb begin
        state_d      = state_q;
        state_d.word = net_out;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign q_o = state_q.word;

    // Checks
    logic armed_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    // R2: zero distance keeps the word intact
    p_zero_amt_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(amt_i) == '0) |-> q_o == $past(data_i));

    // R10: rotation preserves the number of set bits
    p_rot_popcount_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(rot_i)) |-> $countones(q_o) == $countones($past(data_i)));

    // R3: left shift leaves bit 0 clear when moving
    p_left_low_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !$past(rot_i) && !$past(dir_i) && $past(amt_i) != '0) |-> !q_o[0]);

    // R4: logical right shift leaves the MSB clear when moving
    p_right_high_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !$past(rot_i) && !$past(arith_i) && $past(dir_i) && $past(amt_i) != '0)
        |-> !q_o[WIDTH-1]);

    // R5: arithmetic right shift keeps the sign
    p_arith_sign_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !$past(rot_i) && $past(arith_i) && $past(dir_i))
        |-> q_o[WIDTH-1] == $past(data_i[WIDTH-1]));

    // R1: output is zero while reset is held
    always_comb begin
        if (!rst_n) begin
            p_reset_clear_r1: assert (q_o == '0);
        end
    end
endmodule

// File: tb/sim_shf_barrel_top.sv
`timescale 1ns/1ps
module sim_shf_barrel_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] data_i = '0;
    logic [3:0]  amt_i = '0;
    logic        rot_i = 1'b0;
    logic        arith_i = 1'b0;
    logic        dir_i = 1'b0;
    logic [15:0] q_o;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    shf_barrel_top u0 (
        .clk(clk), .rst_n(rst_n), .data_i(data_i), .amt_i(amt_i),
        .rot_i(rot_i), .arith_i(arith_i), .dir_i(dir_i), .q_o(q_o)
    );

    function automatic logic [15:0] model(input logic [15:0] d, input int a,
                                          input logic r, input logic ar, input logic dr);
        logic [31:0] w;
        logic [31:0] ext;
        w = {16'h0, d};
        if (r) begin
            if (a == 0) return d;
            if (!dr) return 16'((w << a) | (w >> (16 - a)));
            return 16'((w >> a) | (w << (16 - a)));
        end
        if (!dr) return 16'(w << a);
        if (ar) begin
            ext = {{16{d[15]}}, d};
            return 16'(ext >> a);
        end
        return 16'(w >> a);
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [15:0] d, input int a, input logic r,
                         input logic ar, input logic dr, input string req);
        @(negedge clk);
        data_i = d; amt_i = 4'(a); rot_i = r; arith_i = ar; dir_i = dr;
        @(negedge clk);
        check(req, q_o, model(d, a, r, ar, dr));
    endtask

    task automatic t_reset;
        data_i = 16'hFFFF; amt_i = 4'd3;
        repeat (2) @(negedge clk);
        check("R1 reset", q_o, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 first result", q_o, 16'hFFF8);
    endtask

    task automatic t_zero_amt;
        for (int m = 0; m < 8; m++)
            apply(16'hA5C3, 0, m[2], m[1], m[0], "R2 zero amount");
    endtask

    task automatic t_examples;
        apply(16'h8000, 1, 1'b0, 1'b0, 1'b0, "R3 0x8000 shl1");
        check("R3 literal", q_o, 16'h0000);
        apply(16'h8000, 1, 1'b1, 1'b0, 1'b0, "R7 0x8000 rol1");
        check("R7 literal", q_o, 16'h0001);
        apply(16'h0001, 1, 1'b1, 1'b0, 1'b1, "R8 0x0001 ror1");
        check("R8 literal", q_o, 16'h8000);
        apply(16'h8421, 4, 1'b0, 1'b1, 1'b1, "R5 sign fill");
        check("R5 literal", q_o, 16'hF842);
        apply(16'h8421, 4, 1'b0, 1'b0, 1'b1, "R4 zero fill");
        check("R4 literal", q_o, 16'h0842);
    endtask

    task automatic t_arith_left;
        logic [15:0] lq;
        apply(16'hC3A5, 5, 1'b0, 1'b0, 1'b0, "R3 logic left");
        lq = q_o;
        apply(16'hC3A5, 5, 1'b0, 1'b1, 1'b0, "R6 arith left");
        check("R6 equals logical", q_o, lq);
    endtask

    task automatic t_rot_ignores_arith;
        logic [15:0] aq;
        for (int a = 1; a < 16; a += 5) begin
            apply(16'h9C31, a, 1'b1, 1'b0, 1'b1, "R9 rot arith0");
            aq = q_o;
            apply(16'h9C31, a, 1'b1, 1'b1, 1'b1, "R9 rot arith1");
            check("R9 arith ignored", q_o, aq);
        end
    endtask

    task automatic t_sweep;
        logic [15:0] pats [3] = '{16'h8001, 16'h7F3E, 16'hB6D9};
        for (int p = 0; p < 3; p++)
            for (int m = 0; m < 8; m++)
                for (int a = 0; a < 16; a++)
                    apply(pats[p], a, m[2], m[1], m[0], "R10 sweep");
    endtask

    initial begin
        t_reset();
        t_zero_amt();
        t_examples();
        t_arith_left();
        t_rot_ignores_arith();
        t_sweep();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule